// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Steering Unit

This unit sits between a 32-bit register file and a 32-bit data memory port and handles accesses that are narrower than a word. On the store side it takes a byte offset, an access size and the register value. It produces the word to write, with the narrow value copied into every lane, and a per-lane write enable that marks only the addressed bytes.

On the load side it takes the word read from memory and picks out the addressed byte or halfword. It returns that value in the low bits of the result, filling the upper bits with zeros or with copies of the value's top bit. A static mode input selects the byte order. In little-endian order the byte at offset 0 is held in bits 7:0 of the word. In big-endian order it is held in bits 31:24.

The steering is combinational. A parameter adds one output register stage. The default build has that stage, so results appear one clock after the inputs. Requests that are not naturally aligned do not trap. They raise a flag and suppress every write enable.

Top module: `lane_steer_unit`

## Requirements
- R1: After reset, and before any request is captured, `memWrData`, `byteEn`, `loadResult` and `misalign` are all zero. With the default output register, every output reflects the inputs of the previous rising clock edge.
- R2: Sizes are encoded on `reqSize` as 00 byte, 01 halfword, 10 word and 11 reserved. For a byte store at offset k, `byteEn` has exactly one bit set. That bit is bit k when `bigEndian`=0 and bit 3-k when `bigEndian`=1. `memWrData` carries `storeData[7:0]` in all four lanes.
- R3: A halfword store at offset 0 enables lanes 1:0 in little-endian order and lanes 3:2 in big-endian order. At offset 2 these are swapped. `memWrData` carries `storeData[15:0]` in both halves.
- R4: A word store at offset 0 sets `byteEn`=1111 and passes `storeData` unchanged to `memWrData`.
- R5: A byte load returns the addressed lane, chosen as in R2, in `loadResult[7:0]`. Bits 31:8 are zero when `signedLoad`=0 and copies of bit 7 of that lane when `signedLoad`=1.
- R6: A halfword load returns the addressed halfword in `loadResult[15:0]`. In little-endian order, the byte at the lower address is the low byte of the halfword. In big-endian order, it is the high byte. Bits 31:16 are zero when unsigned and copies of bit 15 when signed.
- R7: A word load at offset 0 returns `loadWord` unchanged, whatever the values of `signedLoad` and `bigEndian`.
- R8: `misalign` is set, `byteEn` is 0000 and `loadResult` is zero in three cases: a halfword access with offset bit 0 set, a word access with a nonzero offset, and any access with size code 11.
- R9: When `storeReq`=0, `byteEn` is 0000 for every size and offset. Load results are still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low asynchronous reset |
| bigEndian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| storeReq | input | 1 | Current access is a store |
| reqSize | input | 2 | Access size code (00 byte, 01 half, 10 word, 11 reserved) |
| addrOfs | input | 2 | Byte offset of the access within the word |
| signedLoad | input | 1 | Sign-extend narrow load results |
| storeData | input | 32 | Register value to store |
| loadWord | input | 32 | Word read from memory |
| memWrData | output | 32 | Lane-replicated write data |
| byteEn | output | 4 | Per-lane write enables |
| loadResult | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Misaligned or reserved-size request |

## Verification
The assertions assume that `reqSize`, `addrOfs`, `storeReq` and `bigEndian` carry known values on every clock edge after reset. They also assume that `bigEndian` changes only between requests, never in the middle of one.

The stimulus applies each request on the falling edge and holds it across the next rising edge. The request therefore reaches the output stage complete. Every input stays driven to a defined value from before reset is released, including during idle stretches between scenarios.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int HALF_W = 2 * LANE_W;
  localparam int IDX_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // strobes from the decoder to the lane datapath
  typedef struct packed {
    logic [LANES-1:0] laneEn;
    logic [IDX_W-1:0] laneIdx;
    logic             hiHalf;
    size_e            size;
    logic             signExt;
    logic             fault;
  } steer_t;
endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lsu_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bigEndian,
  input  logic             storeReq,
  input  logic [1:0]       reqSize,
  input  logic [IDX_W-1:0] addrOfs,
  input  logic             signedLoad,
  output steer_t           steer
);
  size_e            sizeDec;
  logic [IDX_W-1:0] physIdx;
  logic             faultDec;

  assign sizeDec = size_e'(reqSize);
  // physical lane holding the addressed byte
  assign physIdx = bigEndian ? IDX_W'(LANES - 1) - addrOfs : addrOfs;

  always_comb begin
    unique case (sizeDec)
      SZ_BYTE: faultDec = 1'b0;
      SZ_HALF: faultDec = addrOfs[0];
      SZ_WORD: faultDec = (addrOfs != '0);
      default: faultDec = 1'b1;
    endcase
  end

  always_comb begin
    steer         = '0;
    steer.size    = sizeDec;
    steer.laneIdx = physIdx;
    steer.hiHalf  = addrOfs[1] ^ bigEndian;
    steer.signExt = signedLoad;
    steer.fault   = faultDec;
    if (storeReq && !faultDec) begin
      unique case (sizeDec)
        SZ_BYTE: steer.laneEn[physIdx] = 1'b1;
        SZ_HALF: steer.laneEn = steer.hiHalf ? {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}}
                                             : {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};
        default: steer.laneEn = '1;
      endcase
    end
  end

  // R2: a byte store touches exactly one lane
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && sizeDec == SZ_BYTE) |-> $countones(steer.laneEn) == 1);
  // R3: an aligned halfword store touches one contiguous pair
  p_half_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq && sizeDec == SZ_HALF && !addrOfs[0]) |->
      (steer.laneEn == 4'b0011 || steer.laneEn == 4'b1100));
  // R9: loads never enable writes
  p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !storeReq |-> steer.laneEn == '0);
endmodule

// File: rtl/lane_data.sv
module lane_data
  import lsu_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  steer_t            steer,
  input  logic [WORD_W-1:0] storeData,
  input  logic [WORD_W-1:0] loadWord,
  output logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] ldData
);
  logic [WORD_W-1:0] byteRep;
  logic [WORD_W-1:0] halfRep;
  logic [LANE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_byteRep
      assign byteRep[gi*LANE_W +: LANE_W] = storeData[LANE_W-1:0];
    end
    for (gi = 0; gi < LANES/2; gi++) begin : g_halfRep
      assign halfRep[gi*HALF_W +: HALF_W] = storeData[HALF_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (steer.size)
      SZ_BYTE: wrData = byteRep;
      SZ_HALF: wrData = halfRep;
      default: wrData = storeData;
    endcase
  end

  assign pickByte = loadWord[steer.laneIdx*LANE_W +: LANE_W];
  // big-endian half: lower-address byte is the upper byte, which the
  // physical word layout already provides
  assign pickHalf = steer.hiHalf ? loadWord[WORD_W-1 -: HALF_W] : loadWord[HALF_W-1:0];

  always_comb begin
    if (steer.fault) begin
      ldData = '0;
    end else begin
      unique case (steer.size)
        SZ_BYTE: ldData = {{(WORD_W-LANE_W){steer.signExt & pickByte[LANE_W-1]}}, pickByte};
        SZ_HALF: ldData = {{(WORD_W-HALF_W){steer.signExt & pickHalf[HALF_W-1]}}, pickHalf};
        default: ldData = loadWord;
      endcase
    end
  end

  // R2: byte write data is the same in every lane
  p_byte_replicate_r2: assert property (@(posedge clk) disable iff (!rstN)
    steer.size == SZ_BYTE |-> wrData[WORD_W-1 -: LANE_W] == storeData[LANE_W-1:0]);
  // R5: unsigned byte load has a clean upper part
  p_byte_zero_ext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (steer.size == SZ_BYTE && !steer.signExt) |-> ldData[WORD_W-1:LANE_W] == '0);
  // R6: signed halfword load repeats its top bit
  p_half_sign_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (steer.size == SZ_HALF && steer.signExt && !steer.fault) |->
      ldData[WORD_W-1:HALF_W] == {(WORD_W-HALF_W){ldData[HALF_W-1]}});
endmodule

// File: rtl/lane_steer_unit.sv
module lane_steer_unit
  import lsu_lane_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              storeReq,
  input  logic [1:0]        reqSize,
  input  logic [IDX_W-1:0]  addrOfs,
  input  logic              signedLoad,
  input  logic [WORD_W-1:0] storeData,
  input  logic [WORD_W-1:0] loadWord,
  output logic [WORD_W-1:0] memWrData,
  output logic [LANES-1:0]  byteEn,
  output logic [WORD_W-1:0] loadResult,
  output logic              misalign
);
  steer_t            steer;
  logic [WORD_W-1:0] wrComb;
  logic [WORD_W-1:0] ldComb;

  lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .storeReq(storeReq),
    .reqSize(reqSize), .addrOfs(addrOfs), .signedLoad(signedLoad), .steer(steer)
  );

  lane_data u_data (
    .clk(clk), .rstN(rstN), .steer(steer), .storeData(storeData),
    .loadWord(loadWord), .wrData(wrComb), .ldData(ldComb)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          memWrData  <= '0;
          byteEn     <= '0;
          loadResult <= '0;
          misalign   <= 1'b0;
        end else begin
          memWrData  <= wrComb;
          byteEn     <= steer.laneEn;
          loadResult <= ldComb;
          misalign   <= steer.fault;
        end
      end
    end else begin : g_comb
      assign memWrData  = wrComb;
      assign byteEn     = steer.laneEn;
      assign loadResult = ldComb;
      assign misalign   = steer.fault;
    end
  endgenerate

  // R8: a flagged request writes nothing and returns nothing
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (byteEn == '0 && loadResult == '0));
endmodule

// File: tb/lane_steer_unit_test.sv
`timescale 1ns/1ps
module lane_steer_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bigEndian = 1'b0, storeReq = 1'b0, signedLoad = 1'b0;
  logic [1:0]  reqSize = 2'b00, addrOfs = 2'b00;
  logic [31:0] storeData = '0, loadWord = '0;
  logic [31:0] memWrData, loadResult;
  logic [3:0]  byteEn;
  logic        misalign;
  int          nChecks = 0, nFails = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  lane_steer_unit uut (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .storeReq(storeReq),
    .reqSize(reqSize), .addrOfs(addrOfs), .signedLoad(signedLoad),
    .storeData(storeData), .loadWord(loadWord), .memWrData(memWrData),
    .byteEn(byteEn), .loadResult(loadResult), .misalign(misalign)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at falling edge, capture at rising edge, sample at next falling edge
  task automatic apply(logic be, logic st, logic [1:0] sz, logic [1:0] ofs,
                       logic sg, logic [31:0] sd, logic [31:0] lw);
    @(negedge clk);
    bigEndian = be; storeReq = st; reqSize = sz; addrOfs = ofs;
    signedLoad = sg; storeData = sd; loadWord = lw;
    @(posedge clk);
    @(negedge clk);
  endtask

  // memory byte at address a, derived from the byte-order rule
  function automatic logic [7:0] memByte(logic be, logic [31:0] w, int a);
    return be ? w[8*(3-a) +: 8] : w[8*a +: 8];
  endfunction

  function automatic int laneOf(logic be, int a);
    return be ? 3 - a : a;
  endfunction

  // expected store outputs: n bytes starting at offset ofs
  task automatic expStore(logic be, int n, int ofs, logic [31:0] sd,
                          output logic [3:0] en, output logic [31:0] wd);
    en = '0; wd = '0;
    for (int x = ofs; x < ofs + n; x++) en[laneOf(be, x)] = 1'b1;
    for (int lane = 0; lane < 4; lane++) begin
      int addr = laneOf(be, lane);   // mapping is its own inverse
      int j = addr % n;              // position within the value, in address order
      int sig = be ? (n - 1 - j) : j; // significance of that byte in the value
      wd[8*lane +: 8] = sd[8*sig +: 8];
    end
  endtask

  task automatic t_reset();
    check("R1 wrData", memWrData, 32'h0);
    check("R1 byteEn", {28'h0, byteEn}, 32'h0);
    check("R1 loadResult", loadResult, 32'h0);
    check("R1 misalign", {31'h0, misalign}, 32'h0);
  endtask

  task automatic t_byte_store();
    logic [3:0] en; logic [31:0] wd;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k++) begin
        apply(be[0], 1, 2'b00, k[1:0], 0, 32'hDEAD_BE00 | (k + 8'h40), 32'h0);
        expStore(be[0], 1, k, storeData, en, wd);
        check("R2 byteEn", {28'h0, byteEn}, {28'h0, en});
        check("R2 wrData", memWrData, wd);
        check("R2 misalign", {31'h0, misalign}, 32'h0);
      end
  endtask

  task automatic t_half_store();
    logic [3:0] en; logic [31:0] wd;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k += 2) begin
        apply(be[0], 1, 2'b01, k[1:0], 0, 32'h1234_A5C3 + k, 32'h0);
        expStore(be[0], 2, k, storeData, en, wd);
        check("R3 byteEn", {28'h0, byteEn}, {28'h0, en});
        check("R3 wrData", memWrData, wd);
      end
  endtask

  task automatic t_word_store();
    logic [3:0] en; logic [31:0] wd;
    for (int be = 0; be < 2; be++) begin
      apply(be[0], 1, 2'b10, 2'b00, 0, 32'h8765_4321, 32'h0);
      expStore(be[0], 4, 0, storeData, en, wd);
      check("R4 byteEn", {28'h0, byteEn}, {28'h0, en});
      check("R4 wrData", memWrData, wd);
      check("R4 passthrough", memWrData, 32'h8765_4321);
    end
  endtask

  task automatic t_byte_load();
    logic [7:0] b;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k++)
        for (int sg = 0; sg < 2; sg++) begin
          apply(be[0], 0, 2'b00, k[1:0], sg[0], 32'h0, 32'h81_7F_C0_22);
          b = memByte(be[0], loadWord, k);
          check("R5 byte load", loadResult,
                {{24{sg[0] & b[7]}}, b});
        end
  endtask

  task automatic t_half_load();
    logic [15:0] h;
    for (int be = 0; be < 2; be++)
      for (int k = 0; k < 4; k += 2)
        for (int sg = 0; sg < 2; sg++) begin
          apply(be[0], 0, 2'b01, k[1:0], sg[0], 32'h0, 32'h9A3C_71E5);
          h = be ? {memByte(1, loadWord, k), memByte(1, loadWord, k + 1)}
                 : {memByte(0, loadWord, k + 1), memByte(0, loadWord, k)};
          check("R6 half load", loadResult, {{16{sg[0] & h[15]}}, h});
        end
  endtask

  task automatic t_word_load();
    for (int be = 0; be < 2; be++)
      for (int sg = 0; sg < 2; sg++) begin
        apply(be[0], 0, 2'b10, 2'b00, sg[0], 32'h0, 32'hF00D_8001);
        check("R7 word load", loadResult, 32'hF00D_8001);
      end
  endtask

  task automatic t_misalign();
    logic [1:0] cases_sz [6] = '{2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b11};
    logic [1:0] cases_of [6] = '{2'b01, 2'b11, 2'b01, 2'b10, 2'b11, 2'b00};
    for (int i = 0; i < 6; i++) begin
      apply(i[0], 1, cases_sz[i], cases_of[i], 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R8 misalign", {31'h0, misalign}, 32'h1);
      check("R8 byteEn", {28'h0, byteEn}, 32'h0);
      check("R8 loadResult", loadResult, 32'h0);
    end
  endtask

  task automatic t_no_store();
    for (int sz = 0; sz < 3; sz++)
      for (int k = 0; k < 4; k++) begin
        apply(k[0], 0, sz[1:0], k[1:0], 0, 32'hFFFF_FFFF, 32'h0000_00AB);
        check("R9 byteEn", {28'h0, byteEn}, 32'h0);
      end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_byte_store();
    t_half_store();
    t_word_store();
    t_byte_load();
    t_half_load();
    t_word_load();
    t_misalign();
    t_no_store();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule